// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller Pair

This block joins two eight-input interrupt controllers into a master and a slave so that sixteen interrupt lines can be served. Lines 0 to 7 go to the master and lines 8 to 15 go to the slave. Input 2 of the master does not take external events. It carries the slave's request up to the master.

Each line reaches the block as discrete assert and deassert events rather than as a level. Several sources can share one line. Every pin therefore keeps a count of how many sources are currently asserting it. A per-chip trigger-control register turns changes in that count into request updates, using edge or level rules. Some trigger bits are hard-wired to edge and cannot be written.

When the slave has a pending unmasked request, it forwards that request to master input 2. The master then raises the interrupt output. A pending-vector output gives the base-plus-pin vector of the winning request, and a vector-accept strobe completes the handshake. Software sets a chip's vector base and mask with a configuration write, and the chip accepts no line events until that write has happened.

Top module: `pic_cascade_pair`

## Requirements
- R1: Each pin's assertion count goes up by one on an assert event and down by one on a deassert event, and saturates at both ends. A deassert while the count is zero leaves it at zero and sets the sticky `err_uflow` output, which only reset clears.
- R2: For an edge pin (trigger bit 0), the request is set only when the count goes from 0 to 1. The request stays set after the count returns to zero, until the pin is accepted.
- R3: For a level pin (trigger bit 1), the request is set by any event that leaves the count above zero, and it is cleared when the count goes from 1 to 0. Accepting a level pin does not clear its request.
- R4: A trigger-control write to the master (`tc_sel`=0) stores `tc_wdata & 0xF8`, and a write to the slave (`tc_sel`=1) stores `tc_wdata & 0xDE`. `tc_rdata` returns the stored value of the selected chip, and both values are 0 after reset.
- R5: When the slave has an unmasked request and has not already raised, it marks itself raised and sets the request of master input 2. The master does the same with its own winner and drives `irq_out` high. `irq_out` stays high until the master is accepted.
- R6: Within a chip, the lowest-numbered pin that is requested and unmasked wins. The pending vector is {base, pin} of the master's winner. If the master's winner is input 2, the vector is {slave base, pin} of the slave's winner. `pend_vld` is 0 when there is no such winner.
- R7: On `acc_vld`, if `acc_vec[7:3]` equals the slave base, slave pin `acc_vec[2:0]` and master pin 2 are accepted. Otherwise master pin `acc_vec[2:0]` is accepted. Accepting a pin clears the chip's raised flag and, for an edge pin, its request. Raising is evaluated again in the following cycle.
- R8: A line number `line_num` of 0 to 7 selects master pin `line_num[2:0]`, and 8 to 15 selects slave pin `line_num[2:0]`. Events on line 2 and on lines 16 and above are ignored. `q_masked` returns the mask bit of line `q_line`, and it is 1 for `q_line` of 16 or above.
- R9: After reset every mask bit is 1, the chips are not configured and `irq_out` is 0. A chip that has not been configured ignores line events. A configuration write sets the chip's base and mask, marks it configured and clears its requests and raised flag.
- R10: When an accept and an assert event hit the same edge pin in the same cycle, the accept is applied first, so the request is set again if the count goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Configuration target: 0 master, 1 slave |
| cfg_base | input | 5 | Vector base, upper five vector bits |
| cfg_mask | input | 8 | Per-pin mask, 1 = masked |
| tc_we | input | 1 | Trigger-control write strobe |
| tc_sel | input | 1 | Trigger-control chip select for write and read |
| tc_wdata | input | 8 | Trigger-control write data, 1 = level |
| tc_rdata | output | 8 | Trigger-control value of the selected chip |
| line_vld | input | 1 | Line event strobe |
| line_num | input | 5 | Line number of the event |
| line_up | input | 1 | 1 = assert, 0 = deassert |
| acc_vld | input | 1 | Vector accept strobe |
| acc_vec | input | 8 | Accepted vector |
| q_line | input | 5 | Line number for the mask query |
| q_masked | output | 1 | Mask state of `q_line` |
| irq_out | output | 1 | Interrupt output line |
| pend_vld | output | 1 | A pending vector is available |
| pend_vec | output | 8 | Pending vector |
| err_uflow | output | 1 | Sticky count-underflow flag |

## Verification
The two functions that can fall in the same cycle are the acceptance of a vector and an assert event on the pin that vector names. The bench first lets an edge request latch and drops the line count back to zero. It then drives `acc_vld` and an assert event for that line in the same clock. The result is judged at the ports: the vector must be pending again and `irq_out` must rise again. A separate run with the accept alone must leave nothing pending, which shows that the difference comes from the same-cycle ordering.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PINS     = 8;
  localparam int PIN_W    = 3;
  localparam int BASE_W   = 5;
  localparam int VEC_W    = BASE_W + PIN_W;
  localparam int LINE_W   = 5;
  localparam int CASC_PIN = 2;
  typedef logic [PINS-1:0] pin_vec_t;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] cand,
  output logic         vld,
  output logic [W-1:0] idx
);
  always_comb begin
    vld = |cand;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/pic_pin_track.sv
module pic_pin_track #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_hit,
  input  logic ev_up,
  input  logic level,
  input  logic acc_hit,
  input  logic casc_hit,
  input  logic cfg_clr,
  output logic req,
  output logic uflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic             set_r, clr_r;

  always_comb begin
    cnt_d = cnt_q;
    set_r = 1'b0;
    clr_r = 1'b0;
    uflow = 1'b0;
    if (ev_hit) begin
      if (ev_up) begin
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
        set_r = (cnt_q == '0) | level;
      end else begin
        if (cnt_q == '0) uflow = 1'b1;
        else             cnt_d = cnt_q - CNT_ONE;
        set_r = level & (cnt_d != '0);
        clr_r = level & (cnt_q == CNT_ONE);
      end
    end
    if (casc_hit && ((cnt_q == '0) || level)) set_r = 1'b1;
    req_d = req_q;
    if (acc_hit && !level) req_d = 1'b0;
    if (set_r)             req_d = 1'b1;
    if (clr_r)             req_d = 1'b0;
    if (cfg_clr)           req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req = req_q;

  // R2
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && ev_up && cnt_q == '0 && !cfg_clr) |=> req_q);
  // R3
  lvl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && !ev_up && level && cnt_q == CNT_ONE) |=> !req_q);
  // R1
  uflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && !ev_up && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/pic_chip.sv
module pic_chip
  import pic_pkg::*;
#(
  parameter int       CNT_W     = 4,
  parameter pin_vec_t TRIG_KEEP = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [BASE_W-1:0] cfg_base,
  input  pin_vec_t          cfg_mask,
  input  logic              tc_we,
  input  pin_vec_t          tc_wdata,
  input  logic              ev_vld,
  input  logic [PIN_W-1:0]  ev_pin,
  input  logic              ev_up,
  input  logic              acc_vld,
  input  logic [PIN_W-1:0]  acc_pin,
  input  logic              casc_in,
  output pin_vec_t          mask,
  output pin_vec_t          trig,
  output logic [BASE_W-1:0] base,
  output logic              raised,
  output logic              win_vld,
  output logic [PIN_W-1:0]  win_pin,
  output logic              notify,
  output logic              uflow
);
  logic              ready_q, ready_d;
  pin_vec_t          mask_q, mask_d;
  pin_vec_t          trig_q, trig_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic              raised_q, raised_d;
  logic              uflow_q, uflow_d;
  pin_vec_t          req, pin_uflow;
  logic              ev_ok;

  assign ev_ok = ev_vld & ready_q;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    pic_pin_track #(.CNT_W(CNT_W)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_hit   (ev_ok && (ev_pin == PIN_W'(i))),
      .ev_up    (ev_up),
      .level    (trig_q[i]),
      .acc_hit  (acc_vld && (acc_pin == PIN_W'(i))),
      .casc_hit (casc_in && (i == CASC_PIN)),
      .cfg_clr  (cfg_we),
      .req      (req[i]),
      .uflow    (pin_uflow[i])
    );
  end

  pic_prio #(.N(PINS), .W(PIN_W)) u_prio (
    .cand (req & ~mask_q),
    .vld  (win_vld),
    .idx  (win_pin)
  );

  assign notify = ready_q & win_vld & ~raised_q;

  always_comb begin
    ready_d  = ready_q;
    mask_d   = mask_q;
    base_d   = base_q;
    trig_d   = trig_q;
    raised_d = raised_q;
    uflow_d  = uflow_q | (|pin_uflow);
    if (tc_we) trig_d = tc_wdata & TRIG_KEEP;
    if (acc_vld) raised_d = 1'b0;
    if (notify)  raised_d = 1'b1;
    if (cfg_we) begin
      ready_d  = 1'b1;
      mask_d   = cfg_mask;
      base_d   = cfg_base;
      raised_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      mask_q   <= '1;
      base_q   <= '0;
      trig_q   <= '0;
      raised_q <= 1'b0;
      uflow_q  <= 1'b0;
    end else begin
      ready_q  <= ready_d;
      mask_q   <= mask_d;
      base_q   <= base_d;
      trig_q   <= trig_d;
      raised_q <= raised_d;
      uflow_q  <= uflow_d;
    end
  end

  assign mask   = mask_q;
  assign trig   = trig_q;
  assign base   = base_q;
  assign raised = raised_q;
  assign uflow  = uflow_q;

  // R9
  unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_q |-> (req == '0));
  // R5
  casc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (casc_in && !cfg_we) |=> req[CASC_PIN]);
endmodule

// File: rtl/pic_cascade_pair.sv
module pic_cascade_pair
  import pic_pkg::*;
#(
  parameter int       CNT_W       = 4,
  parameter pin_vec_t M_TRIG_KEEP = 8'hF8,
  parameter pin_vec_t S_TRIG_KEEP = 8'hDE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [4:0]  cfg_base,
  input  logic [7:0]  cfg_mask,
  input  logic        tc_we,
  input  logic        tc_sel,
  input  logic [7:0]  tc_wdata,
  output logic [7:0]  tc_rdata,
  input  logic        line_vld,
  input  logic [4:0]  line_num,
  input  logic        line_up,
  input  logic        acc_vld,
  input  logic [7:0]  acc_vec,
  input  logic [4:0]  q_line,
  output logic        q_masked,
  output logic        irq_out,
  output logic        pend_vld,
  output logic [7:0]  pend_vec,
  output logic        err_uflow
);
  pin_vec_t          m_mask, s_mask, m_trig, s_trig;
  logic [BASE_W-1:0] m_base, s_base;
  logic              m_raised, s_raised, m_win_vld, s_win_vld;
  logic [PIN_W-1:0]  m_win_pin, s_win_pin, m_acc_pin;
  logic              m_notify, s_notify, m_uflow, s_uflow;
  logic              m_ev, s_ev, from_slave;

  assign m_ev = line_vld && (line_num[4:3] == 2'b00) &&
                (line_num[2:0] != PIN_W'(CASC_PIN));
  assign s_ev = line_vld && (line_num[4:3] == 2'b01);

  assign from_slave = (acc_vec[VEC_W-1:PIN_W] == s_base);
  assign m_acc_pin  = from_slave ? PIN_W'(CASC_PIN) : acc_vec[PIN_W-1:0];

  pic_chip #(.CNT_W(CNT_W), .TRIG_KEEP(M_TRIG_KEEP)) u_master (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we && !cfg_sel),
    .cfg_base (cfg_base),
    .cfg_mask (cfg_mask),
    .tc_we    (tc_we && !tc_sel),
    .tc_wdata (tc_wdata),
    .ev_vld   (m_ev),
    .ev_pin   (line_num[2:0]),
    .ev_up    (line_up),
    .acc_vld  (acc_vld),
    .acc_pin  (m_acc_pin),
    .casc_in  (s_notify),
    .mask     (m_mask),
    .trig     (m_trig),
    .base     (m_base),
    .raised   (m_raised),
    .win_vld  (m_win_vld),
    .win_pin  (m_win_pin),
    .notify   (m_notify),
    .uflow    (m_uflow)
  );

  pic_chip #(.CNT_W(CNT_W), .TRIG_KEEP(S_TRIG_KEEP)) u_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we && cfg_sel),
    .cfg_base (cfg_base),
    .cfg_mask (cfg_mask),
    .tc_we    (tc_we && tc_sel),
    .tc_wdata (tc_wdata),
    .ev_vld   (s_ev),
    .ev_pin   (line_num[2:0]),
    .ev_up    (line_up),
    .acc_vld  (acc_vld && from_slave),
    .acc_pin  (acc_vec[PIN_W-1:0]),
    .casc_in  (1'b0),
    .mask     (s_mask),
    .trig     (s_trig),
    .base     (s_base),
    .raised   (s_raised),
    .win_vld  (s_win_vld),
    .win_pin  (s_win_pin),
    .notify   (s_notify),
    .uflow    (s_uflow)
  );

  always_comb begin
    if (m_win_vld && (m_win_pin == PIN_W'(CASC_PIN))) begin
      pend_vld = s_win_vld;
      pend_vec = {s_base, s_win_pin};
    end else begin
      pend_vld = m_win_vld;
      pend_vec = {m_base, m_win_pin};
    end
  end

  always_comb begin
    case (q_line[4:3])
      2'b00:   q_masked = m_mask[q_line[2:0]];
      2'b01:   q_masked = s_mask[q_line[2:0]];
      default: q_masked = 1'b1;
    endcase
  end

  assign tc_rdata  = tc_sel ? s_trig : m_trig;
  assign irq_out   = m_raised;
  assign err_uflow = m_uflow | s_uflow;

  // R7
  slave_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && from_slave && s_raised && m_raised) |=> (!s_raised && !m_raised));
  // R5
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(m_notify));
endmodule

// File: tb/test_pic_cascade_pair.sv
`timescale 1ns/1ps
module test_pic_cascade_pair;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we, cfg_sel, tc_we, tc_sel, line_vld, line_up, acc_vld;
  logic [4:0] cfg_base, line_num, q_line;
  logic [7:0] cfg_mask, tc_wdata, acc_vec, tc_rdata, pend_vec;
  logic       q_masked, irq_out, pend_vld, err_uflow;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  pic_cascade_pair i_pic_cascade_pair (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_base(cfg_base), .cfg_mask(cfg_mask), .tc_we(tc_we), .tc_sel(tc_sel),
    .tc_wdata(tc_wdata), .tc_rdata(tc_rdata), .line_vld(line_vld),
    .line_num(line_num), .line_up(line_up), .acc_vld(acc_vld), .acc_vec(acc_vec),
    .q_line(q_line), .q_masked(q_masked), .irq_out(irq_out),
    .pend_vld(pend_vld), .pend_vec(pend_vec), .err_uflow(err_uflow)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_base = 0; cfg_mask = 0;
    tc_we = 0; tc_sel = 0; tc_wdata = 0; line_vld = 0; line_num = 0;
    line_up = 0; acc_vld = 0; acc_vec = 0; q_line = 0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic line_ev(input int l, input bit up);
    line_num = 5'(l); line_up = up; line_vld = 1'b1;
    tick(1);
    line_vld = 1'b0;
  endtask

  task automatic accept(input int v);
    acc_vec = 8'(v); acc_vld = 1'b1;
    tick(1);
    acc_vld = 1'b0;
  endtask

  task automatic cfg(input bit sel, input int b, input int m);
    cfg_sel = sel; cfg_base = 5'(b); cfg_mask = 8'(m); cfg_we = 1'b1;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic tcw(input bit sel, input int d);
    tc_sel = sel; tc_wdata = 8'(d); tc_we = 1'b1;
    tick(1);
    tc_we = 1'b0;
  endtask

  function automatic int exp_vec(input int l);
    return (l < 8) ? (8'h20 + l) : (8'h28 + l - 8);
  endfunction

  task automatic idle_chk(input string tag);
    tick(4);
    chk(tag, irq_out, 0);
    chk(tag, pend_vld, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R9 reset state
    chk("R9 reset irq", irq_out, 0);
    chk("R9 reset pend", pend_vld, 0);
    chk("R1 reset err", err_uflow, 0);
    q_line = 0; tick(1);
    chk("R9 reset mask", q_masked, 1);
    tc_sel = 0; tick(1); chk("R4 reset master trig", tc_rdata, 0);
    tc_sel = 1; tick(1); chk("R4 reset slave trig", tc_rdata, 0);

    // R4 trigger write sweep
    for (int v = 0; v < 256; v++) begin
      tcw(0, v); tc_sel = 0; tick(1);
      chk("R4 master trig", tc_rdata, v & 8'hF8);
      tcw(1, v); tc_sel = 1; tick(1);
      chk("R4 slave trig", tc_rdata, v & 8'hDE);
    end

    // R9 unconfigured slave ignores events: a later deassert underflows
    do_reset();
    cfg(0, 5'h04, 0);
    line_ev(9, 1);
    tick(4);
    chk("R9 unready no pend", pend_vld, 0);
    cfg(1, 5'h05, 0);
    line_ev(9, 0);
    tick(2);
    chk("R9 ignored event leaves count zero", err_uflow, 1);

    // fresh configuration
    do_reset();
    cfg(0, 5'h04, 8'hA5);
    cfg(1, 5'h05, 8'h3C);
    // R8 mask query sweep
    for (int l = 0; l < 32; l++) begin
      q_line = 5'(l); tick(1);
      chk("R8 mask query", q_masked,
          (l < 8) ? ((8'hA5 >> l) & 1) : (l < 16) ? ((8'h3C >> (l - 8)) & 1) : 1);
    end
    cfg(0, 5'h04, 0);
    cfg(1, 5'h05, 0);

    // R8 line 2 and lines above 15 are ignored
    line_ev(2, 1);
    idle_chk("R8 line 2 ignored");
    line_ev(18, 1);
    idle_chk("R8 line 18 ignored");

    // R5 R6 R7 R8 single edge line sweep
    for (int l = 0; l < 16; l++) begin
      if (l == 2) continue;
      line_ev(l, 1);
      tick(4);
      chk("R5 irq raised", irq_out, 1);
      chk("R6 pend valid", pend_vld, 1);
      chk("R8 R6 vector", pend_vec, exp_vec(l));
      accept(exp_vec(l));
      line_ev(l, 0);
      idle_chk("R7 accept clears");
    end

    // R2 edge latched after count returns to zero
    line_ev(11, 1);
    line_ev(11, 0);
    tick(4);
    chk("R2 latched pend", pend_vld, 1);
    chk("R2 latched vec", pend_vec, 8'h2B);
    accept(8'h2B);
    idle_chk("R2 latched accept");

    // R2 R1 shared edge line counting
    line_ev(3, 1);
    line_ev(3, 1);
    tick(4);
    chk("R2 shared vec", pend_vec, 8'h23);
    accept(8'h23);
    line_ev(3, 0);
    idle_chk("R1 2->1 no request");
    line_ev(3, 1);
    idle_chk("R2 1->2 no request");
    line_ev(3, 0);
    line_ev(3, 0);
    line_ev(3, 1);
    tick(4);
    chk("R2 0->1 again", pend_vec, 8'h23);
    chk("R2 0->1 again vld", pend_vld, 1);
    accept(8'h23);
    line_ev(3, 0);
    idle_chk("R2 cleanup");

    // R6 priority within master, and cascade winning
    line_ev(6, 1);
    line_ev(1, 1);
    tick(4);
    chk("R6 lowest pin wins", pend_vec, 8'h21);
    accept(8'h21);
    tick(4);
    chk("R6 next winner", pend_vec, 8'h26);
    accept(8'h26);
    line_ev(6, 0); line_ev(1, 0);
    idle_chk("R6 cleanup a");
    line_ev(4, 1);
    line_ev(10, 1);
    tick(4);
    chk("R6 cascade beats pin 4", pend_vec, 8'h2A);
    accept(8'h2A);
    tick(4);
    chk("R7 master pin after slave accept", pend_vec, 8'h24);
    chk("R7 irq re-raised", irq_out, 1);
    accept(8'h24);
    line_ev(4, 0); line_ev(10, 0);
    idle_chk("R6 cleanup b");

    // R3 level master line 5
    tcw(0, 8'h20);
    line_ev(5, 1);
    tick(4);
    chk("R3 level pend", pend_vec, 8'h25);
    accept(8'h25);
    tick(4);
    chk("R3 level survives accept", pend_vld, 1);
    chk("R3 level re-raise", irq_out, 1);
    line_ev(5, 1);
    line_ev(5, 0);
    tick(4);
    chk("R3 level count 2->1 holds", pend_vld, 1);
    line_ev(5, 0);
    tick(4);
    chk("R3 level 1->0 clears", pend_vld, 0);
    accept(8'h25);
    idle_chk("R3 level cleanup");

    // R3 level slave line 12 (slave bit 4)
    tcw(1, 8'h10);
    line_ev(12, 1);
    tick(4);
    chk("R3 slave level vec", pend_vec, 8'h2C);
    accept(8'h2C);
    tick(4);
    chk("R3 R5 slave level re-cascade", pend_vec, 8'h2C);
    chk("R3 slave level irq", irq_out, 1);
    line_ev(12, 0);
    tick(4);
    chk("R3 slave level cleared", pend_vld, 0);
    accept(8'h2C);
    idle_chk("R3 slave cleanup");
    tcw(0, 0); tcw(1, 0);

    // R10 accept alone vs accept with same-cycle assert
    line_ev(3, 1);
    line_ev(3, 0);
    tick(4);
    accept(8'h23);
    idle_chk("R10 accept alone");
    line_ev(3, 1);
    line_ev(3, 0);
    tick(4);
    acc_vec = 8'h23; acc_vld = 1'b1;
    line_num = 5'd3; line_up = 1'b1; line_vld = 1'b1;
    tick(1);
    acc_vld = 1'b0; line_vld = 1'b0;
    tick(4);
    chk("R10 request re-set", pend_vld, 1);
    chk("R10 vector", pend_vec, 8'h23);
    chk("R10 irq", irq_out, 1);
    accept(8'h23);
    line_ev(3, 0);
    idle_chk("R10 cleanup");

    // R1 underflow sets sticky flag, count stays at zero
    chk("R1 no error yet", err_uflow, 0);
    line_ev(7, 0);
    tick(2);
    chk("R1 underflow flag", err_uflow, 1);
    line_ev(7, 1);
    tick(4);
    chk("R1 count stayed zero", pend_vec, 8'h27);
    chk("R1 flag sticky", err_uflow, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule